// File: doc/BRIEF.md
# Dual-Channel Serial Port Interrupt Status Logic

This block holds the interrupt bookkeeping of a two-channel serial port that a CPU reaches over a simple register bus. Channel A carries the console and channel B the auxiliary line. The serializers, FIFOs and baud logic are outside the block. They report an arriving character with a one-cycle `rx_arrive` pulse and a level `rx_avail`, and they present the oldest byte on `rx_data`. The block hands a transmit byte over with a one-cycle `tx_load` strobe.

The CPU sees five kinds of register. Each channel has a line status register, a command register and a holding register. One shared address holds the interrupt mask on write and returns the interrupt status on read. Any set status bit drives one shared, level-sensitive interrupt output. A periodic `tick` input is divided down internally. Each divided event marks both transmitters as ready, so that software keeps draining its output queues even when it misses an edge.

Bus reads are combinational from the current state. Read and write side effects take hold at the clock edge on which `bus_rd` or `bus_wr` is high. The bus never asserts `bus_rd` and `bus_wr` in the same cycle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the interrupt status, the interrupt mask, the interrupt output and the tick divider.
- R2: The interrupt status byte uses bit 0 = channel A transmit-ready, bit 1 = channel A receive-ready, bit 4 = channel B transmit-ready and bit 5 = channel B receive-ready. Its other bits read 0. A write to offset 0x42C loads the mask, using the same bit positions. A read of 0x42C returns the status byte, not the mask.
- R3: A read of line status A (0x40C) or line status B (0x44C) returns bit 0 equal to that channel's `rx_avail` and bit 2 always 1. All other bits read 0.
- R4: An `rx_arrive` pulse sets that channel's receive-ready status bit and raises `irq` only when the matching mask bit is 1. With the mask bit 0, the status and `irq` are left unchanged.
- R5: A read of holding A (0x41C) or holding B (0x45C) returns that channel's `rx_data`. It pulses that channel's `rx_take` and clears only that channel's receive-ready bit.
- R6: A write to holding A or holding B pulses that channel's `tx_load`, with `tx_data` equal to the written byte. It clears only that channel's transmit-ready bit.
- R7: Every second `tick` pulse is a tick event, and the divider restarts after each event whatever the mask holds. On a tick event, if mask bit 0 or mask bit 4 is 1, both transmit-ready bits are set and `irq` is raised.
- R8: `irq` is a level. Once raised, it stays high until a read of line status A or a reset. A read of line status B does not lower it.
- R9: A write to command A (0x414) or command B (0x454) with data bit 3 set pulses that channel's `flush` in the same cycle. With bit 3 clear, no flush occurs.
- R10: A read of any unmapped offset returns 0. A write to an unmapped offset changes neither the status nor the mask.
- R11: When an event that sets a status bit falls in the same cycle as an access that clears it, the bit ends up set. When a new interrupt event falls in the same cycle as a line status A read, `irq` ends up high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| rx_arrive_a | input | 1 | Channel A character-arrival pulse |
| rx_arrive_b | input | 1 | Channel B character-arrival pulse |
| rx_avail_a | input | 1 | Channel A has a received byte |
| rx_avail_b | input | 1 | Channel B has a received byte |
| rx_data_a | input | 8 | Channel A oldest received byte |
| rx_data_b | input | 8 | Channel B oldest received byte |
| tick | input | 1 | Periodic timer pulse |
| rx_take_a | output | 1 | Channel A byte consumed |
| rx_take_b | output | 1 | Channel B byte consumed |
| tx_load_a | output | 1 | Channel A transmit byte strobe |
| tx_load_b | output | 1 | Channel B transmit byte strobe |
| tx_data | output | 8 | Byte for the transmit strobe |
| flush_a | output | 1 | Channel A transmit flush pulse |
| flush_b | output | 1 | Channel B transmit flush pulse |
| irq | output | 1 | Combined interrupt level |

## Verification
Two pairs of functions can meet on one clock edge. First, a status bit can be set and cleared together: a character arrives while the CPU reads that channel's holding register, or a tick event falls while the CPU writes a transmit byte. Second, `irq` can be raised while the CPU reads line status A, which is the read that lowers it. Directed steps line up an arrival or a second tick with the clearing access in the same cycle, and the following status read must show the bit set and `irq` high. Random traffic creates many more such collisions, and each result is compared with a bench model in which set wins.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFF_LSR_A  = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_CMD_A  = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_HOLD_A = 12'h41C;
    localparam logic [ADDR_W-1:0] OFF_IRQ    = 12'h42C;
    localparam logic [ADDR_W-1:0] OFF_LSR_B  = 12'h44C;
    localparam logic [ADDR_W-1:0] OFF_CMD_B  = 12'h454;
    localparam logic [ADDR_W-1:0] OFF_HOLD_B = 12'h45C;

    // status bit positions
    localparam int ST_TXA = 0;
    localparam int ST_RXA = 1;
    localparam int ST_TXB = 4;
    localparam int ST_RXB = 5;

    // command and line status field positions
    localparam int CMD_FLUSH_BIT = 3;
    localparam int LSR_RX_BIT    = 0;
    localparam int LSR_TX_BIT    = 2;

    typedef struct packed {
        logic lsr_a_rd;
        logic lsr_b_rd;
        logic hold_a_rd;
        logic hold_b_rd;
        logic hold_a_wr;
        logic hold_b_wr;
        logic cmd_a_wr;
        logic cmd_b_wr;
        logic mask_wr;
        logic stat_rd;
    } acc_t;

    typedef struct packed {
        logic rx_b;
        logic tx_b;
        logic rx_a;
        logic tx_a;
    } mask_t;

    function automatic logic [DATA_W-1:0] line_status(input logic avail);
        logic [DATA_W-1:0] v;
        v = '0;
        v[LSR_RX_BIT] = avail;
        v[LSR_TX_BIT] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
    import uart_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output acc_t              acc
);
    always_comb begin
        acc           = '0;
        acc.lsr_a_rd  = rd && (addr == OFF_LSR_A);
        acc.lsr_b_rd  = rd && (addr == OFF_LSR_B);
        acc.hold_a_rd = rd && (addr == OFF_HOLD_A);
        acc.hold_b_rd = rd && (addr == OFF_HOLD_B);
        acc.stat_rd   = rd && (addr == OFF_IRQ);
        acc.hold_a_wr = wr && (addr == OFF_HOLD_A);
        acc.hold_b_wr = wr && (addr == OFF_HOLD_B);
        acc.cmd_a_wr  = wr && (addr == OFF_CMD_A);
        acc.cmd_b_wr  = wr && (addr == OFF_CMD_B);
        acc.mask_wr   = wr && (addr == OFF_IRQ);
    end
endmodule

// File: rtl/uart_irq_tick.sv
module uart_irq_tick #(
    parameter int TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic evt
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    assign evt = tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  mask_t             mask_in,
    input  logic              lsr_a_rd,
    input  logic              hold_a_rd,
    input  logic              hold_b_rd,
    input  logic              hold_a_wr,
    input  logic              hold_b_wr,
    input  logic              rx_arrive_a,
    input  logic              rx_arrive_b,
    input  logic              tick_evt,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    mask_t             mask;
    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] clr_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (rx_arrive_a && mask.rx_a) set_v[ST_RXA] = 1'b1;
        if (rx_arrive_b && mask.rx_b) set_v[ST_RXB] = 1'b1;
        if (tick_evt && (mask.tx_a || mask.tx_b)) begin
            set_v[ST_TXA] = 1'b1;
            set_v[ST_TXB] = 1'b1;
        end
        if (hold_a_rd) clr_v[ST_RXA] = 1'b1;
        if (hold_b_rd) clr_v[ST_RXB] = 1'b1;
        if (hold_a_wr) clr_v[ST_TXA] = 1'b1;
        if (hold_b_wr) clr_v[ST_TXB] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (status & ~clr_v) | set_v;
            irq    <= (irq && !lsr_a_rd) || (|set_v);
            if (mask_wr) mask <= mask_in;
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_arrive_a,
    input  logic              rx_arrive_b,
    input  logic              rx_avail_a,
    input  logic              rx_avail_b,
    input  logic [DATA_W-1:0] rx_data_a,
    input  logic [DATA_W-1:0] rx_data_b,
    input  logic              tick,
    output logic              rx_take_a,
    output logic              rx_take_b,
    output logic              tx_load_a,
    output logic              tx_load_b,
    output logic [DATA_W-1:0] tx_data,
    output logic              flush_a,
    output logic              flush_b,
    output logic              irq
);
    acc_t              acc;
    logic              tick_evt;
    logic [DATA_W-1:0] status;
    mask_t             mask_in;

    uart_irq_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .acc  (acc)
    );

    uart_irq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .evt  (tick_evt)
    );

    assign mask_in = '{rx_b: bus_wdata[ST_RXB], tx_b: bus_wdata[ST_TXB],
                       rx_a: bus_wdata[ST_RXA], tx_a: bus_wdata[ST_TXA]};

    uart_irq_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .mask_wr     (acc.mask_wr),
        .mask_in     (mask_in),
        .lsr_a_rd    (acc.lsr_a_rd),
        .hold_a_rd   (acc.hold_a_rd),
        .hold_b_rd   (acc.hold_b_rd),
        .hold_a_wr   (acc.hold_a_wr),
        .hold_b_wr   (acc.hold_b_wr),
        .rx_arrive_a (rx_arrive_a),
        .rx_arrive_b (rx_arrive_b),
        .tick_evt    (tick_evt),
        .status      (status),
        .irq         (irq)
    );

    assign rx_take_a = acc.hold_a_rd;
    assign rx_take_b = acc.hold_b_rd;
    assign tx_load_a = acc.hold_a_wr;
    assign tx_load_b = acc.hold_b_wr;
    assign tx_data   = bus_wdata;
    assign flush_a   = acc.cmd_a_wr && bus_wdata[CMD_FLUSH_BIT];
    assign flush_b   = acc.cmd_b_wr && bus_wdata[CMD_FLUSH_BIT];

    always_comb begin
        bus_rdata = '0;
        if (acc.lsr_a_rd)  bus_rdata = line_status(rx_avail_a);
        if (acc.lsr_b_rd)  bus_rdata = line_status(rx_avail_b);
        if (acc.hold_a_rd) bus_rdata = rx_data_a;
        if (acc.hold_b_rd) bus_rdata = rx_data_b;
        if (acc.stat_rd)   bus_rdata = status;
    end
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
    import uart_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_arrive_a,
    input logic              rx_arrive_b,
    input logic              tick,
    input logic              rx_take_a,
    input logic              rx_take_b,
    input logic              tx_load_a,
    input logic              tx_load_b,
    input logic              flush_a,
    input logic              flush_b,
    input logic              irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_rd && bus_addr == OFF_LSR_A)) |=> irq);

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rx_arrive_a || rx_arrive_b || tick));

    // R3
    lsr_txbit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == OFF_LSR_A || bus_addr == OFF_LSR_B)) |-> bus_rdata[LSR_TX_BIT]);

    // R9
    flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush_a, flush_b}));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_load_a, tx_load_b, rx_take_a, rx_take_b}));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[11:8] != 4'h4) |-> (bus_rdata == '0));
endmodule

bind uart_irq_ctrl uart_irq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .rx_arrive_a (rx_arrive_a),
    .rx_arrive_b (rx_arrive_b),
    .tick        (tick),
    .rx_take_a   (rx_take_a),
    .rx_take_b   (rx_take_b),
    .tx_load_a   (tx_load_a),
    .tx_load_b   (tx_load_b),
    .flush_a     (flush_a),
    .flush_b     (flush_b),
    .irq         (irq)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        rx_arrive_a, rx_arrive_b, rx_avail_a, rx_avail_b;
    logic [7:0]  rx_data_a, rx_data_b, tx_data;
    logic        tick, rx_take_a, rx_take_b, tx_load_a, tx_load_b;
    logic        flush_a, flush_b, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [7:0] m_st, m_mask;
    logic       m_irq;
    int         m_cnt;

    always #4 clk = ~clk;

    uart_irq_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_arrive_a(rx_arrive_a), .rx_arrive_b(rx_arrive_b),
        .rx_avail_a(rx_avail_a), .rx_avail_b(rx_avail_b),
        .rx_data_a(rx_data_a), .rx_data_b(rx_data_b), .tick(tick),
        .rx_take_a(rx_take_a), .rx_take_b(rx_take_b),
        .tx_load_a(tx_load_a), .tx_load_b(tx_load_b), .tx_data(tx_data),
        .flush_a(flush_a), .flush_b(flush_b), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic bit is_mapped(input logic [11:0] a);
        return a == 12'h40C || a == 12'h414 || a == 12'h41C || a == 12'h42C ||
               a == 12'h44C || a == 12'h454 || a == 12'h45C;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h40C: return {5'b0, 1'b1, 1'b0, rx_avail_a};
            12'h44C: return {5'b0, 1'b1, 1'b0, rx_avail_b};
            12'h41C: return rx_data_a;
            12'h45C: return rx_data_b;
            12'h42C: return m_st;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [11:0] a);
        case (a)
            12'h40C, 12'h44C: return "R3";
            12'h41C, 12'h45C: return "R5";
            12'h42C:          return "R2";
            default:          return "R10";
        endcase
    endfunction

    // one bus cycle: drive at negedge, check combinational outputs, advance model
    task automatic step(input logic rd, input logic wr, input logic [11:0] a,
                        input logic [7:0] wd, input logic ra, input logic rb, input logic tk);
        logic [7:0] set_v, clr_v;
        bit evt;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        rx_arrive_a = ra; rx_arrive_b = rb; tick = tk;
        rx_avail_a = 1'($urandom); rx_avail_b = 1'($urandom);
        rx_data_a = 8'($urandom); rx_data_b = 8'($urandom);
        #1;
        if (rd) chk(rd_tag(a), bus_rdata, exp_rd(a));
        chk("R9 flush", {flush_a, flush_b},
            {wr && a == 12'h414 && wd[3], wr && a == 12'h454 && wd[3]});
        chk("R6 tx_load", {tx_load_a, tx_load_b, tx_data},
            {wr && a == 12'h41C, wr && a == 12'h45C, wd});
        chk("R5 rx_take", {rx_take_a, rx_take_b}, {rd && a == 12'h41C, rd && a == 12'h45C});
        set_v = 8'h00; clr_v = 8'h00; evt = 1'b0;
        if (tk) begin
            if (m_cnt == 1) begin evt = 1'b1; m_cnt = 0; end
            else m_cnt = 1;
        end
        if (ra && m_mask[1]) set_v[1] = 1'b1;
        if (rb && m_mask[5]) set_v[5] = 1'b1;
        if (evt && (m_mask[0] || m_mask[4])) set_v = set_v | 8'h11;
        if (rd && a == 12'h41C) clr_v[1] = 1'b1;
        if (rd && a == 12'h45C) clr_v[5] = 1'b1;
        if (wr && a == 12'h41C) clr_v[0] = 1'b1;
        if (wr && a == 12'h45C) clr_v[4] = 1'b1;
        m_irq = (m_irq && !(rd && a == 12'h40C)) || (set_v != 0);
        m_st  = (m_st & ~clr_v) | set_v;
        if (wr && a == 12'h42C) m_mask = wd & 8'h33;
        @(posedge clk);
        #2;
        chk("R8 irq", irq, m_irq);
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic idle();
        step(0, 0, 12'h000, 8'h00, 0, 0, 0);
    endtask

    task automatic read_st(input string tag, input logic [7:0] exp);
        step(1, 0, 12'h42C, 8'h00, 0, 0, 0);
        chk(tag, m_st, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_mask = 0; m_irq = 0; m_cnt = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] a;
        void'($urandom(32'd2024));
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        rx_arrive_a = 0; rx_arrive_b = 0; tick = 0;
        rx_avail_a = 0; rx_avail_b = 0; rx_data_a = 0; rx_data_b = 0;
        rst = 1'b0;
        do_reset();
        // R1 reset state
        #1 chk("R1 irq after reset", irq, 1'b0);
        read_st("R1 status after reset", 8'h00);

        // R4 masked arrival has no effect
        step(0, 0, 12'h000, 8'h00, 1, 1, 0);
        chk("R4 masked irq", irq, 1'b0);
        read_st("R4 masked status", 8'h00);

        // R2 mask load; status readback not mask
        step(0, 1, 12'h42C, 8'hFF, 0, 0, 0);
        read_st("R2 status not mask", 8'h00);

        // R4 enabled arrival on A
        step(0, 0, 12'h000, 8'h00, 1, 0, 0);
        chk("R4 irq raised", irq, 1'b1);
        read_st("R4 rx A bit", 8'h02);

        // R8 status B read keeps irq, status A read clears it
        step(1, 0, 12'h44C, 8'h00, 0, 0, 0);
        chk("R8 irq after lsr B", irq, 1'b1);
        step(1, 0, 12'h40C, 8'h00, 0, 0, 0);
        chk("R8 irq after lsr A", irq, 1'b0);

        // R5 holding A read clears rx A only
        step(0, 0, 12'h000, 8'h00, 0, 1, 0);
        step(1, 0, 12'h41C, 8'h00, 0, 0, 0);
        read_st("R5 rx A cleared", 8'h20);

        // R7 two ticks set both tx bits
        step(0, 0, 12'h000, 8'h00, 0, 0, 1);
        read_st("R7 first tick no event", 8'h20);
        step(0, 0, 12'h000, 8'h00, 0, 0, 1);
        read_st("R7 second tick", 8'h31);

        // R6 holding B write clears tx B only
        step(0, 1, 12'h45C, 8'hA5, 0, 0, 0);
        read_st("R6 tx B cleared", 8'h21);

        // R11 clear and set in same cycle: tick event with holding A write
        step(0, 0, 12'h000, 8'h00, 0, 0, 1);
        step(0, 1, 12'h41C, 8'h3C, 0, 0, 1);
        read_st("R11 set wins", 8'h31);
        // R11 irq event with lsr A read
        step(1, 0, 12'h40C, 8'h00, 1, 0, 0);
        chk("R11 irq set wins", irq, 1'b1);

        // R10 unmapped write ignored
        step(0, 1, 12'h42D, 8'h00, 0, 0, 0);
        step(0, 1, 12'h7F0, 8'h00, 0, 0, 0);
        read_st("R10 status kept", 8'h33);
        step(1, 0, 12'h42E, 8'h00, 0, 0, 0);

        // R9 flush with and without bit 3
        step(0, 1, 12'h414, 8'h08, 0, 0, 0);
        step(0, 1, 12'h454, 8'hF7, 0, 0, 0);

        // R7 tick event with tx mask bits off sets nothing but restarts divider
        step(0, 1, 12'h42C, 8'h22, 0, 0, 0);
        step(1, 0, 12'h41C, 8'h00, 0, 0, 0);
        step(1, 0, 12'h45C, 8'h00, 0, 0, 0);
        step(1, 0, 12'h40C, 8'h00, 0, 0, 0);
        step(0, 0, 12'h000, 8'h00, 0, 0, 1);
        step(0, 0, 12'h000, 8'h00, 0, 0, 1);
        chk("R7 masked tick irq", irq, 1'b0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom_range(0, 12));
            case (op)
                0:  a = 12'h40C;
                1:  a = 12'h44C;
                2:  a = 12'h41C;
                3:  a = 12'h45C;
                4:  a = 12'h42C;
                5:  a = 12'h414;
                6:  a = 12'h454;
                7:  a = 12'h42C;
                8:  a = 12'h41C;
                9:  a = 12'h45C;
                default: begin
                    a = 12'($urandom);
                    if (is_mapped(a)) a = 12'h800;
                end
            endcase
            if (op == 12) idle();
            else if (op <= 4 || op == 10)
                step(1, 0, a, 8'h00, ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0),
                     ($urandom_range(0, 2) == 0));
            else
                step(0, 1, a, 8'($urandom), ($urandom_range(0, 4) == 0),
                     ($urandom_range(0, 4) == 0), ($urandom_range(0, 2) == 0));
        end

        // R1 reset mid-run clears everything
        do_reset();
        #1 chk("R1 irq after second reset", irq, 1'b0);
        read_st("R1 status after second reset", 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule